// File: doc/BRIEF.md
# FEC Channel Output Formatter

This block sits between an error-correction decoder and the external channel-output pins. The decoder hands it one corrected byte at a time. Each byte carries a type tag: payload, check or gap. The first byte of a frame also carries a frame-error tag. The block turns this stream into either a byte bus or a serial bit stream. Alongside the data it drives a data-valid strobe, a frame-start marker, a per-frame uncorrectable-error flag and a per-unit output strobe that serves as the bit clock.

In parallel mode each accepted byte appears on the bus for one cycle. In serial mode the block runs at the bit rate and shifts each byte out over eight cycles, most significant bit first. The decoder paces its bytes to no more than one every eight cycles in that mode. A requested mode change is only applied at the first byte of a frame, so a frame is never split across modes. Check and gap bytes travel through the data path with the valid strobe held low. The error flag covers the whole frame, lines up with the data, and has a selectable polarity. A soft reset clears the output state. An active-low output enable only switches the pad drivers and never stalls the pipeline.

Top module: `chan_out_fmt`

## Requirements
- R1: While `rst` is held and on the first cycle after it is released, `co_dv`, `co_fs` and `co_stb` are 0, and `co_err` is at its inactive level (1 when `err_pol` is 0).
- R2: In parallel mode a byte accepted with `in_vld` appears on `co_data` in the next cycle with `co_stb` at 1, for exactly that one cycle. `co_dv` is 1 only when `in_kind` is payload (code 0).
- R3: A byte of kind check (code 1) or gap (code 2) is still placed on the outputs, but `co_dv` stays 0 for all of its output cycles.
- R4: In parallel mode `co_fs` is 1 for the single output cycle of a payload byte accepted with `in_sof`, and 0 for every other byte.
- R5: In serial mode an accepted byte is shifted out on `co_data[0]` over the eight cycles that follow acceptance, most significant bit first. `co_stb` is 1 in each of those cycles and `co_data[7:1]` is 0.
- R6: In serial mode `co_dv` is 1 for all eight bits of a payload byte. `co_fs` is 1 only for the first bit of the frame's first payload byte.
- R7: The error flag takes the frame-error tag given with `in_sof`. It becomes active on the first output cycle of a frame whose tag is 1. It holds through the rest of that frame and any idle cycles, and changes only at the first output of the next frame.
- R8: With `err_pol` at 0 an active error drives `co_err` to 0. With `err_pol` at 1 it drives `co_err` to 1. The change of polarity shows on the same cycle.
- R9: `co_fs` is never 1 while `co_dv` is 0.
- R10: One cycle after `soft_rst` is sampled high, `co_dv`, `co_fs` and `co_stb` are 0 and `co_err` is inactive.
- R11: `co_oe` is the inverse of `oe_n`. While it is 0, shifting and framing keep advancing, so output resumes at the bit position reached in the meantime.
- R12: `ser_req` (1 = serial) is applied only on a byte accepted with `in_sof`. Bytes within a frame keep that frame's mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Control bit that clears framing and output state |
| oe_n | input | 1 | Active-low pad driver enable |
| err_pol | input | 1 | Error flag polarity, 1 = active high |
| ser_req | input | 1 | Requested output mode, 1 = serial |
| in_vld | input | 1 | Byte present from the decoder |
| in_byte | input | 8 | Corrected byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_ferr | input | 1 | Frame holds an uncorrectable error (with `in_sof`) |
| in_kind | input | 2 | Byte kind: 0 payload, 1 check, 2 gap |
| co_data | output | 8 | Byte bus, or serial bit on bit 0 |
| co_dv | output | 1 | Output holds payload data |
| co_fs | output | 1 | Frame-start marker |
| co_err | output | 1 | Frame error flag |
| co_stb | output | 1 | Output unit strobe (bit clock) |
| co_oe | output | 1 | Pad tristate enable, 1 = drive |

## Verification
The checker watches four properties on every cycle. Frame-start never appears without data-valid. A check or gap byte never raises data-valid. The error pin holds still inside a frame unless the polarity changes. Soft reset lands on inactive outputs one cycle later. The directed scenarios cover what a single-cycle property cannot. These are the serial bit order and the eight-cycle strobe window, the parallel one-cycle timing, the error flag following the tag at frame edges, a mode request deferred until the next frame start, and shifting continuing while the pad drivers are off.

// File: rtl/cof_pkg.sv
package cof_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        KIND_PAY = 2'd0,
        KIND_CHK = 2'd1,
        KIND_GAP = 2'd2
    } byte_kind_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              dv;
        logic              fs;
        logic              stb;
    } out_beat_t;

    function automatic logic is_payload(input logic [1:0] kind);
        return kind == KIND_PAY;
    endfunction

endpackage

// File: rtl/cof_frame_ctl.sv
module cof_frame_ctl (
    input  logic clk,
    input  logic clr,
    input  logic in_vld,
    input  logic in_sof,
    input  logic in_ferr,
    input  logic ser_req,
    output logic frame_err,
    output logic ser_act,
    output logic ser_now
);
    logic frame_edge;

    assign frame_edge = in_vld && in_sof;
    assign ser_now    = frame_edge ? ser_req : ser_act;

    always_ff @(posedge clk) begin
        if (clr) begin
            frame_err <= 1'b0;
            ser_act   <= 1'b0;
        end else if (frame_edge) begin
            frame_err <= in_ferr;
            ser_act   <= ser_req;
        end
    end
endmodule

// File: rtl/cof_par_stage.sv
module cof_par_stage
    import cof_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    input  logic              payload,
    input  logic              sof,
    output out_beat_t         beat
);
    always_ff @(posedge clk) begin
        if (clr) begin
            beat <= '0;
        end else if (load) begin
            beat.data <= din;
            beat.dv   <= payload;
            beat.fs   <= payload && sof;
            beat.stb  <= 1'b1;
        end else begin
            beat.dv   <= 1'b0;
            beat.fs   <= 1'b0;
            beat.stb  <= 1'b0;
        end
    end
endmodule

// File: rtl/cof_serializer.sv
module cof_serializer
    import cof_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    input  logic              payload,
    input  logic              sof,
    output out_beat_t         beat
);
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  left;
    logic              pay_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            beat  <= '0;
            shreg <= '0;
            left  <= '0;
            pay_q <= 1'b0;
        end else if (load) begin
            beat.data <= {{(BYTE_W-1){1'b0}}, din[BYTE_W-1]};
            beat.dv   <= payload;
            beat.fs   <= payload && sof;
            beat.stb  <= 1'b1;
            shreg     <= din << 1;
            left      <= CNT_W'(BYTE_W-1);
            pay_q     <= payload;
        end else if (left != '0) begin
            beat.data <= {{(BYTE_W-1){1'b0}}, shreg[BYTE_W-1]};
            beat.dv   <= pay_q;
            beat.fs   <= 1'b0;
            beat.stb  <= 1'b1;
            shreg     <= shreg << 1;
            left      <= left - 1'b1;
        end else begin
            beat.dv   <= 1'b0;
            beat.fs   <= 1'b0;
            beat.stb  <= 1'b0;
        end
    end
endmodule

// File: rtl/chan_out_fmt.sv
module chan_out_fmt
    import cof_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              oe_n,
    input  logic              err_pol,
    input  logic              ser_req,
    input  logic              in_vld,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_sof,
    input  logic              in_ferr,
    input  logic [1:0]        in_kind,
    output logic [BYTE_W-1:0] co_data,
    output logic              co_dv,
    output logic              co_fs,
    output logic              co_err,
    output logic              co_stb,
    output logic              co_oe
);
    logic      clr;
    logic      frame_err;
    logic      ser_act;
    logic      ser_now;
    logic      payload;
    out_beat_t par_beat;
    out_beat_t ser_beat;
    out_beat_t sel_beat;

    assign clr     = rst || soft_rst;
    assign payload = is_payload(in_kind);

    cof_frame_ctl u_ctl (
        .clk       (clk),
        .clr       (clr),
        .in_vld    (in_vld),
        .in_sof    (in_sof),
        .in_ferr   (in_ferr),
        .ser_req   (ser_req),
        .frame_err (frame_err),
        .ser_act   (ser_act),
        .ser_now   (ser_now)
    );

    cof_par_stage u_par (
        .clk     (clk),
        .clr     (clr),
        .load    (in_vld && !ser_now),
        .din     (in_byte),
        .payload (payload),
        .sof     (in_sof),
        .beat    (par_beat)
    );

    cof_serializer u_ser (
        .clk     (clk),
        .clr     (clr),
        .load    (in_vld && ser_now),
        .din     (in_byte),
        .payload (payload),
        .sof     (in_sof),
        .beat    (ser_beat)
    );

    assign sel_beat = ser_act ? ser_beat : par_beat;

    assign co_data = sel_beat.data;
    assign co_dv   = sel_beat.dv;
    assign co_fs   = sel_beat.fs;
    assign co_stb  = sel_beat.stb;
    assign co_err  = ~(frame_err ^ err_pol);
    assign co_oe   = ~oe_n;
endmodule

// File: rtl/cof_chk.sv
module cof_chk (
    input logic       clk,
    input logic       rst,
    input logic       soft_rst,
    input logic       err_pol,
    input logic       in_vld,
    input logic       in_sof,
    input logic [1:0] in_kind,
    input logic       co_dv,
    input logic       co_fs,
    input logic       co_err,
    input logic       co_stb
);
    // R9
    fs_needs_dv_chk: assert property (@(posedge clk) disable iff (rst)
        co_fs |-> co_dv);

    // R10
    soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (!co_dv && !co_fs && !co_stb && (co_err == !err_pol)));

    // R3
    nonpay_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_kind != 2'd0 && !soft_rst) |=> !co_dv);

    // R7
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(in_vld && in_sof) && !soft_rst) |=> ($stable(co_err) || !$stable(err_pol)));
endmodule

bind chan_out_fmt cof_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .err_pol  (err_pol),
    .in_vld   (in_vld),
    .in_sof   (in_sof),
    .in_kind  (in_kind),
    .co_dv    (co_dv),
    .co_fs    (co_fs),
    .co_err   (co_err),
    .co_stb   (co_stb)
);

// File: tb/tb_chan_out_fmt.sv
module tb_chan_out_fmt;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       soft_rst = 1'b0;
    logic       oe_n = 1'b0;
    logic       err_pol = 1'b0;
    logic       ser_req = 1'b0;
    logic       in_vld = 1'b0;
    logic [7:0] in_byte = '0;
    logic       in_sof = 1'b0;
    logic       in_ferr = 1'b0;
    logic [1:0] in_kind = 2'd0;
    logic [7:0] co_data;
    logic       co_dv, co_fs, co_err, co_stb, co_oe;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_out_fmt dut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .oe_n(oe_n),
        .err_pol(err_pol), .ser_req(ser_req), .in_vld(in_vld),
        .in_byte(in_byte), .in_sof(in_sof), .in_ferr(in_ferr),
        .in_kind(in_kind), .co_data(co_data), .co_dv(co_dv),
        .co_fs(co_fs), .co_err(co_err), .co_stb(co_stb), .co_oe(co_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Present one byte; returns at the negedge where its first output unit is visible.
    task automatic push(input logic [7:0] b, input logic sof, input logic ferr, input logic [1:0] kind);
        @(negedge clk);
        in_vld = 1'b1; in_byte = b; in_sof = sof; in_ferr = ferr; in_kind = kind;
        @(negedge clk);
        in_vld = 1'b0; in_sof = 1'b0; in_ferr = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 dv in reset", co_dv, 0);
        check("R1 fs in reset", co_fs, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 stb after reset", co_stb, 0);
        check("R1 err inactive", co_err, 1);
    endtask

    task automatic t_parallel();
        push(8'hA5, 1, 0, 2'd0);
        check("R2 data", co_data, 8'hA5);
        check("R2 stb", co_stb, 1);
        check("R2 dv payload", co_dv, 1);
        check("R4 fs first byte", co_fs, 1);
        @(negedge clk);
        check("R2 stb one cycle", co_stb, 0);
        check("R2 dv one cycle", co_dv, 0);
        push(8'h3C, 0, 0, 2'd0);
        check("R4 no fs later byte", co_fs, 0);
        check("R2 dv second", co_dv, 1);
        push(8'h11, 0, 0, 2'd1);
        check("R3 check byte data", co_data, 8'h11);
        check("R3 check byte dv", co_dv, 0);
        push(8'h22, 0, 0, 2'd2);
        check("R3 gap byte stb", co_stb, 1);
        check("R3 gap byte dv", co_dv, 0);
    endtask

    task automatic t_error();
        push(8'h01, 1, 1, 2'd0);
        check("R7 err at first output", co_err, 0);
        push(8'h02, 0, 0, 2'd0);
        check("R7 err held in frame", co_err, 0);
        repeat (3) @(negedge clk);
        check("R7 err held idle", co_err, 0);
        err_pol = 1'b1;
        #1;
        check("R8 active high", co_err, 1);
        err_pol = 1'b0;
        push(8'h03, 1, 0, 2'd0);
        check("R7 err cleared next frame", co_err, 1);
    endtask

    task automatic t_serial();
        logic [7:0] b = 8'hB2;
        ser_req = 1'b1;
        push(b, 1, 0, 2'd0);
        for (int i = 7; i >= 0; i--) begin
            check("R5 serial bit", co_data, {7'd0, b[i]});
            check("R5 serial stb", co_stb, 1);
            check("R6 serial dv", co_dv, 1);
            check("R6 serial fs", co_fs, (i == 7) ? 1 : 0);
            check("R9 fs implies dv", co_fs & ~co_dv, 0);
            @(negedge clk);
        end
        check("R5 stb ends", co_stb, 0);
        push(8'hFF, 0, 0, 2'd1);
        for (int i = 0; i < 8; i++) begin
            check("R3 serial check dv", co_dv, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_mode();
        ser_req = 1'b0;
        push(8'h81, 0, 0, 2'd0);
        check("R12 stays serial bit7", co_data, 8'h01);
        @(negedge clk);
        check("R12 stays serial bit6", co_data, 8'h00);
        repeat (6) @(negedge clk);
        check("R12 stays serial bit0", co_data, 8'h01);
        @(negedge clk);
        push(8'h5A, 1, 0, 2'd0);
        check("R12 parallel at frame start", co_data, 8'h5A);
        check("R12 parallel fs", co_fs, 1);
        @(negedge clk);
        check("R12 parallel single strobe", co_stb, 0);
    endtask

    task automatic t_oe();
        logic [7:0] b = 8'h96;
        ser_req = 1'b1;
        push(b, 1, 0, 2'd0);
        check("R11 oe on", co_oe, 1);
        oe_n = 1'b1;
        #1;
        check("R11 oe off", co_oe, 0);
        repeat (3) @(negedge clk);
        oe_n = 1'b0;
        #1;
        check("R11 oe back", co_oe, 1);
        check("R11 shift advanced", co_data, {7'd0, b[4]});
        check("R11 still valid", co_dv, 1);
        repeat (5) @(negedge clk);
        ser_req = 1'b0;
    endtask

    task automatic t_soft();
        push(8'h44, 1, 1, 2'd0);
        check("R10 pre err active", co_err, 0);
        @(negedge clk);
        in_vld = 1'b1; in_byte = 8'h55; in_kind = 2'd0;
        soft_rst = 1'b1;
        @(negedge clk);
        in_vld = 1'b0; soft_rst = 1'b0;
        check("R10 dv cleared", co_dv, 0);
        check("R10 stb cleared", co_stb, 0);
        check("R10 err inactive", co_err, 1);
    endtask

    initial begin
        t_reset();
        t_parallel();
        t_error();
        t_serial();
        t_mode();
        t_oe();
        t_soft();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule